// File: doc/BRIEF.md
# Sampling Converter Serial Readout

This block is the digital half of a serial sampling converter. A host requests a conversion with a falling edge on the read/convert strobe while the active-low select is asserted. The block then freezes the sample word presented on its parallel input, holds a ready flag low for a fixed number of system clock cycles, and stores the coded result. The result is formatted as straight binary or as two's complement, MSB first, and padded with trailing zeros to the serial word width.

The stored word is read out serially in one of two ways, chosen by a static mode input, and both always return the result of the conversion before the one in progress. In self-clocked mode the convert command also launches a burst of exactly one word's worth of clock pulses, generated by the block, with the data alongside. In host-clocked mode the host supplies the bit clock. A one-cycle frame pulse marks the start of the read, and a marker input is chained in behind the data word so that several converters can be daisy-chained. A sleep input blocks conversions and keeps the stored result. The select, strobe and host clock arrive asynchronously and are synchronised before edge detection.

Top module: `sampled_serial_out`

## Requirements
- R1: After reset, ready_o is 1, gen_clk_o is 0, sdo_o is 0 and frame_o is 0.
- R2: A falling edge on rdconv_i while sel_n_i is 0 (and sleep_i is 0) drives ready_o low for exactly CONV_CYCLES system clock cycles, after which it returns to 1.
- R3: A falling edge on rdconv_i while sel_n_i is 1 starts nothing: ready_o stays 1 and no clock pulse appears on gen_clk_o.
- R4: With ext_mode_i at 0, an accepted convert command produces exactly WORD_W (16) rising edges on gen_clk_o. The previous result is sent MSB first, sdo_o changes only as gen_clk_o falls, and gen_clk_o rests at 0 afterwards. The serial word is {12-bit code, 4'b0000}.
- R5: With no transfer running, sdo_o shows the level mark_i had when the most recent accepted conversion started; later changes of mark_i do not reach it.
- R6: With ext_mode_i at 1, a rising edge on rdconv_i while sel_n_i is 0 gives one single-cycle frame_o pulse. It also loads the previous result, whose MSB is on sdo_o before the first host clock fall. The word advances by one bit after each falling edge of host_clk_i.
- R7: With ext_mode_i at 1, a falling edge on sel_n_i while rdconv_i is 1 starts the same read as R6, with one frame_o pulse.
- R8: In a host-clocked read, once the 16 data bits have been shifted out, sdo_o presents the mark_i levels sampled at successive host clock falls, in the order they were sampled, until sel_n_i rises or rdconv_i falls.
- R9: straight_i at 1 stores the sample unchanged. straight_i at 0 stores it with its MSB inverted, which gives two's complement.
- R10: While sleep_i is 1, convert commands are refused (ready_o stays 1), and the stored result is unchanged for the next read.
- R11: A convert command arriving while ready_o is 0 is ignored: the busy span is not extended and the running burst is not restarted.
- R12: The sample is frozen when the conversion starts; changes on sample_i during the busy span do not affect the stored result.
- R13: A read started while a conversion is running returns the result stored before that conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Active-low select, asynchronous |
| rdconv_i | input | 1 | Read/convert strobe, asynchronous |
| ext_mode_i | input | 1 | 1 selects host-clocked readout, 0 self-clocked burst |
| host_clk_i | input | 1 | Host-supplied bit clock, asynchronous |
| sleep_i | input | 1 | Blocks conversions while 1 |
| straight_i | input | 1 | 1 straight binary, 0 two's complement |
| mark_i | input | 1 | Marker bit, captured at convert or chained after data |
| sample_i | input | SAMPLE_W | Digital sample from the converter core |
| ready_o | output | 1 | Low while a conversion runs |
| gen_clk_o | output | 1 | Self-generated bit clock in self-clocked mode |
| sdo_o | output | 1 | Serial data |
| frame_o | output | 1 | One-cycle pulse at the start of a host-clocked read |

## Verification
The bench aims at the places where the two readout paths meet the conversion timer. A second strobe inside the busy span would lengthen ready_o or restart the burst in a design that re-arms. A read that overlaps a conversion would return the new code if the shift register were loaded from the sample instead of the stored word. A sample changed mid-conversion would leak into the result if it were not frozen. It also checks the marker behaviour: a design that samples mark_i live would show the wrong idle level, and one that does not chain the marker in would show zeros behind the data word. Sleep and deselect are checked by showing that no busy span and no burst occur, and that the old word still comes out afterwards.

// File: rtl/sro_pkg.sv
package sro_pkg;

    // Raw asynchronous control pins, grouped so they share one synchroniser
    typedef struct packed {
        logic sel_n;
        logic rdconv;
        logic hclk;
    } pins_t;

    // Single-cycle events derived from the synchronised pins
    typedef struct packed {
        logic rc_fall;
        logic rc_rise;
        logic sel_fall;
        logic sel_rise;
        logic hclk_fall;
    } edges_t;

    // Which serial transfer, if any, owns the shift register
    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_SELF = 2'd1,
        XF_HOST = 2'd2
    } xfer_mode_e;

    // Pin levels that correspond to "nothing happening"
    function automatic pins_t pins_quiet();
        pins_t p;
        p.sel_n  = 1'b1;
        p.rdconv = 1'b1;
        p.hclk   = 1'b0;
        return p;
    endfunction

    // Edge extraction from current and previous synchronised levels
    function automatic edges_t find_edges(pins_t now, pins_t prev);
        edges_t e;
        e.rc_fall   = prev.rdconv & ~now.rdconv;
        e.rc_rise   = ~prev.rdconv & now.rdconv;
        e.sel_fall  = prev.sel_n & ~now.sel_n;
        e.sel_rise  = ~prev.sel_n & now.sel_n;
        e.hclk_fall = prev.hclk & ~now.hclk;
        return e;
    endfunction

endpackage

// File: rtl/sro_sync.sv
module sro_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= rst_val;
                else     stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= rst_val;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sro_conv.sv
module sro_conv #(
    parameter int unsigned SAMPLE_W    = 12,
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned CONV_CYCLES = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic                sleep,
    input  logic                straight,
    input  logic                mark,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                ready,
    output logic                start,
    output logic [WORD_W-1:0]   result,
    output logic                mark_hold
);

    localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1);
    localparam int unsigned PAD_W = WORD_W - SAMPLE_W;

    logic [CNT_W-1:0]    left_q;
    logic [SAMPLE_W-1:0] held_q;
    logic [SAMPLE_W-1:0] code;

    // A request is honoured only when idle and awake
    assign start = req & ready & ~sleep;

    // Offset coding: two's complement differs from straight binary in the MSB
    always_comb begin
        code = held_q;
        if (!straight) code[SAMPLE_W-1] = ~held_q[SAMPLE_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready     <= 1'b1;
            left_q    <= '0;
            held_q    <= '0;
            result    <= '0;
            mark_hold <= 1'b0;
        end else if (start) begin
            ready     <= 1'b0;
            left_q    <= CNT_W'(CONV_CYCLES - 1);
            held_q    <= sample;
            mark_hold <= mark;
        end else if (!ready) begin
            if (left_q == '0) begin
                ready  <= 1'b1;
                result <= {code, {PAD_W{1'b0}}};
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/sro_shift.sv
module sro_shift
    import sro_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned HALF_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              self_start,
    input  logic              host_start,
    input  logic              host_stop,
    input  logic              hclk_fall,
    input  logic              mark_live,
    input  logic              mark_hold,
    input  logic [WORD_W-1:0] load_word,
    output logic              sdo,
    output logic              gen_clk,
    output logic              frame
);

    localparam int unsigned HC_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam int unsigned BC_W = $clog2(WORD_W + 1);

    xfer_mode_e        mode_q;
    logic [WORD_W-1:0] sh_q;
    logic [HC_W-1:0]   half_q;
    logic              lvl_q;
    logic [BC_W-1:0]   left_q;
    logic              frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= XF_IDLE;
            sh_q    <= '0;
            half_q  <= '0;
            lvl_q   <= 1'b0;
            left_q  <= '0;
            frame_q <= 1'b0;
        end else begin
            frame_q <= host_start;
            if (host_start) begin
                mode_q <= XF_HOST;
                sh_q   <= load_word;
                lvl_q  <= 1'b0;
            end else if (self_start) begin
                mode_q <= XF_SELF;
                sh_q   <= load_word;
                lvl_q  <= 1'b0;
                half_q <= HC_W'(HALF_CYCLES - 1);
                left_q <= BC_W'(WORD_W);
            end else begin
                case (mode_q)
                    XF_HOST: begin
                        if (host_stop) begin
                            mode_q <= XF_IDLE;
                        end else if (hclk_fall) begin
                            // daisy chain: marker enters behind the data
                            sh_q <= {sh_q[WORD_W-2:0], mark_live};
                        end
                    end
                    XF_SELF: begin
                        if (half_q == '0) begin
                            half_q <= HC_W'(HALF_CYCLES - 1);
                            lvl_q  <= ~lvl_q;
                            if (lvl_q) begin
                                sh_q   <= sh_q << 1;
                                left_q <= left_q - 1'b1;
                                if (left_q == BC_W'(1)) mode_q <= XF_IDLE;
                            end
                        end else begin
                            half_q <= half_q - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sdo     = (mode_q == XF_IDLE) ? mark_hold : sh_q[WORD_W-1];
    assign gen_clk = (mode_q == XF_SELF) & lvl_q;
    assign frame   = frame_q;

endmodule

// File: rtl/sampled_serial_out.sv
module sampled_serial_out
    import sro_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = 12,
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned CONV_CYCLES = 20,
    parameter int unsigned HALF_CYCLES = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_n_i,
    input  logic                rdconv_i,
    input  logic                ext_mode_i,
    input  logic                host_clk_i,
    input  logic                sleep_i,
    input  logic                straight_i,
    input  logic                mark_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                ready_o,
    output logic                gen_clk_o,
    output logic                sdo_o,
    output logic                frame_o
);

    pins_t             pin_raw;
    pins_t             pin_s;
    pins_t             pin_q;
    edges_t            ev;
    logic              sel_low;
    logic              conv_req;
    logic              conv_start;
    logic              self_start;
    logic              host_start;
    logic              host_stop;
    logic [WORD_W-1:0] result;
    logic              mark_hold;

    always_comb begin
        pin_raw.sel_n  = sel_n_i;
        pin_raw.rdconv = rdconv_i;
        pin_raw.hclk   = host_clk_i;
    end

    sro_sync #(
        .STAGES (SYNC_STAGES),
        .W      ($bits(pins_t))
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d       (pin_raw),
        .rst_val (pins_quiet()),
        .q       (pin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) pin_q <= pins_quiet();
        else     pin_q <= pin_s;
    end

    assign ev       = find_edges(pin_s, pin_q);
    assign sel_low  = ~pin_s.sel_n;
    assign conv_req = ev.rc_fall & sel_low;

    assign host_start = ext_mode_i &
                        ((ev.rc_rise & sel_low) | (ev.sel_fall & pin_s.rdconv));
    assign host_stop  = ext_mode_i & (ev.sel_rise | ev.rc_fall);
    assign self_start = conv_start & ~ext_mode_i;

    sro_conv #(
        .SAMPLE_W    (SAMPLE_W),
        .WORD_W      (WORD_W),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_conv (
        .clk       (clk),
        .rst       (rst),
        .req       (conv_req),
        .sleep     (sleep_i),
        .straight  (straight_i),
        .mark      (mark_i),
        .sample    (sample_i),
        .ready     (ready_o),
        .start     (conv_start),
        .result    (result),
        .mark_hold (mark_hold)
    );

    sro_shift #(
        .WORD_W      (WORD_W),
        .HALF_CYCLES (HALF_CYCLES)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .self_start (self_start),
        .host_start (host_start),
        .host_stop  (host_stop),
        .hclk_fall  (ev.hclk_fall),
        .mark_live  (mark_i),
        .mark_hold  (mark_hold),
        .load_word  (result),
        .sdo        (sdo_o),
        .gen_clk    (gen_clk_o),
        .frame      (frame_o)
    );

endmodule

// File: rtl/sro_checker.sv
module sro_checker #(
    parameter int unsigned CONV_CYCLES = 20,
    parameter int unsigned WORD_W      = 16
) (
    input logic clk,
    input logic rst,
    input logic ready_o,
    input logic gen_clk_o,
    input logic frame_o,
    input logic sleep_i,
    input logic sel_low,
    input logic conv_start
);

    int unsigned low_cnt;
    int unsigned rise_cnt;
    logic        gen_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= 0;
            rise_cnt <= 0;
            gen_prev <= 1'b0;
        end else begin
            gen_prev <= gen_clk_o;
            if (!ready_o) low_cnt <= low_cnt + 1;
            else          low_cnt <= 0;
            if (conv_start)                  rise_cnt <= 0;
            else if (gen_clk_o && !gen_prev) rise_cnt <= rise_cnt + 1;
        end
    end

    assert_busy_span_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> (low_cnt == CONV_CYCLES));

    assert_deselect_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!sel_low && ready_o) |=> ready_o);

    assert_burst_len_R4: assert property (@(posedge clk) disable iff (rst)
        rise_cnt <= WORD_W);

    assert_frame_single_R6: assert property (@(posedge clk) disable iff (rst)
        frame_o |=> !frame_o);

    assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (sleep_i && ready_o) |=> ready_o);

endmodule

bind sampled_serial_out sro_checker #(
    .CONV_CYCLES (CONV_CYCLES),
    .WORD_W      (WORD_W)
) u_sro_chk (
    .clk        (clk),
    .rst        (rst),
    .ready_o    (ready_o),
    .gen_clk_o  (gen_clk_o),
    .frame_o    (frame_o),
    .sleep_i    (sleep_i),
    .sel_low    (sel_low),
    .conv_start (conv_start)
);

// File: tb/sampled_serial_out_bench.sv
module sampled_serial_out_bench;

    localparam int CONV_CYCLES = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel_n_i, rdconv_i, ext_mode_i, host_clk_i;
    logic        sleep_i, straight_i, mark_i;
    logic [11:0] sample_i;
    logic        ready_o, gen_clk_o, sdo_o, frame_o;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sampled_serial_out #(
        .SAMPLE_W    (12),
        .WORD_W      (16),
        .CONV_CYCLES (CONV_CYCLES),
        .HALF_CYCLES (2),
        .SYNC_STAGES (2)
    ) u_sampled_serial_out (
        .clk        (clk),
        .rst        (rst),
        .sel_n_i    (sel_n_i),
        .rdconv_i   (rdconv_i),
        .ext_mode_i (ext_mode_i),
        .host_clk_i (host_clk_i),
        .sleep_i    (sleep_i),
        .straight_i (straight_i),
        .mark_i     (mark_i),
        .sample_i   (sample_i),
        .ready_o    (ready_o),
        .gen_clk_o  (gen_clk_o),
        .sdo_o      (sdo_o),
        .frame_o    (frame_o)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // R1: reset state
    task automatic test_reset();
        rst = 1'b1;
        sel_n_i = 1'b1; rdconv_i = 1'b1; ext_mode_i = 1'b0; host_clk_i = 1'b0;
        sleep_i = 1'b0; straight_i = 1'b1; mark_i = 1'b0; sample_i = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "ready", ready_o, 1);
        chk("R1", "gen_clk", gen_clk_o, 0);
        chk("R1", "sdo", sdo_o, 0);
        chk("R1", "frame", frame_o, 0);
    endtask

    // Self-clocked convert command; observes busy span, burst and idle level
    task automatic conv_int(input string rq, input logic [11:0] smp,
                            input logic [11:0] late, input bit straight,
                            input bit tag, input bit desel, input bit slp,
                            input bit second, input int exp_low,
                            input int exp_rises, input logic [15:0] exp_word,
                            input bit exp_tag);
        int          low = 0;
        int          rises = 0;
        logic        prev_clk = 1'b0;
        logic [15:0] word = '0;
        ext_mode_i = 1'b0;
        sample_i = smp; straight_i = straight; mark_i = tag; sleep_i = slp;
        sel_n_i = desel; rdconv_i = 1'b1;
        repeat (4) @(negedge clk);
        rdconv_i = 1'b0;
        for (int c = 0; c < 150; c++) begin
            @(negedge clk);
            if (c == 4) rdconv_i = 1'b1;
            if (second && c == 8)  rdconv_i = 1'b0;
            if (second && c == 11) rdconv_i = 1'b1;
            if (!ready_o) begin
                low++;
                sample_i = late;
                mark_i = ~tag;
            end
            if (gen_clk_o && !prev_clk) begin
                if (rises < 16) word[15-rises] = sdo_o;
                rises++;
            end
            prev_clk = gen_clk_o;
        end
        sel_n_i = 1'b1; sleep_i = 1'b0;
        chk(rq, "busy cycles (R2)", low, exp_low);
        chk(rq, "clock rises (R4)", rises, exp_rises);
        if (exp_rises != 0) chk(rq, "burst word (R4)", word, exp_word);
        chk(rq, "clock at rest (R4)", gen_clk_o, 0);
        chk(rq, "idle data level (R5)", sdo_o, exp_tag);
        @(negedge clk);
    endtask

    // One host clock step: capture sdo, raise clock, lower it
    task automatic host_step(output logic bit_out, input logic tag_bit,
                             inout int frames, inout int low);
        bit_out = sdo_o;
        mark_i = tag_bit;
        host_clk_i = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (frame_o) frames++;
            if (!ready_o) low++;
        end
        host_clk_i = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (frame_o) frames++;
            if (!ready_o) low++;
        end
    endtask

    // Host-clocked read, started by strobe rise (R6) or select fall (R7)
    task automatic host_read(input string rq, input bit by_sel,
                             input logic [15:0] exp_word, input logic [3:0] tags);
        int          frames = 0;
        int          low = 0;
        logic [15:0] got = '0;
        logic [3:0]  gtag = '0;
        logic        b;
        ext_mode_i = 1'b1; host_clk_i = 1'b0; mark_i = 1'b0;
        @(negedge clk);
        if (by_sel) begin
            rdconv_i = 1'b1; sel_n_i = 1'b1;
            repeat (6) @(negedge clk);
            sel_n_i = 1'b0;
        end else begin
            sel_n_i = 1'b1; rdconv_i = 1'b0;
            repeat (6) @(negedge clk);
            sel_n_i = 1'b0;
            repeat (6) @(negedge clk);
            rdconv_i = 1'b1;
        end
        repeat (8) begin
            @(negedge clk);
            if (frame_o) frames++;
        end
        for (int k = 0; k < 20; k++) begin
            host_step(b, (k < 4) ? tags[3-k] : 1'b0, frames, low);
            if (k < 16) got[15-k] = b;
            else        gtag[19-k] = b;
        end
        sel_n_i = 1'b1;
        repeat (6) @(negedge clk);
        rdconv_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(rq, "frame pulses", frames, 1);
        chk(rq, "read word", got, exp_word);
        chk("R8", "chained markers", gtag, tags);
        chk(rq, "no conversion from read", low, 0);
    endtask

    // R13: read launched during a conversion returns the earlier result
    task automatic read_during_conv();
        int          frames = 0;
        int          low = 0;
        logic [15:0] got = '0;
        logic        b;
        ext_mode_i = 1'b1; host_clk_i = 1'b0; mark_i = 1'b0;
        sel_n_i = 1'b1; rdconv_i = 1'b1;
        sample_i = 12'h9AB; straight_i = 1'b0;
        repeat (6) @(negedge clk);
        sel_n_i = 1'b0;
        repeat (6) @(negedge clk);
        rdconv_i = 1'b0;
        repeat (2) begin
            @(negedge clk);
            if (!ready_o) low++;
        end
        rdconv_i = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (!ready_o) low++;
            if (frame_o) frames++;
        end
        chk("R13", "ready low during read start", ready_o, 0);
        for (int k = 0; k < 16; k++) begin
            host_step(b, 1'b0, frames, low);
            got[15-k] = b;
        end
        sel_n_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R13", "word during conversion", got, 16'h4560);
        chk("R2", "busy cycles host mode", low, CONV_CYCLES);
        chk("R6", "frame pulses", frames, 1);
    endtask

    initial begin
        test_reset();
        // R2 R4 R5: first burst carries the reset result
        conv_int("R4", 12'hA5C, 12'hA5C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
                 CONV_CYCLES, 16, 16'h0000, 1'b1);
        // R9: straight word from previous conversion; this one two's complement
        conv_int("R9", 12'h3F1, 12'h3F1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                 CONV_CYCLES, 16, 16'hA5C0, 1'b0);
        // R3: deselected strobe
        conv_int("R3", 12'h777, 12'h777, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0,
                 0, 0, 16'h0000, 1'b0);
        // R10: sleeping
        conv_int("R10", 12'h123, 12'h123, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0,
                 0, 0, 16'h0000, 1'b0);
        // R10 R12 R9: kept result comes out; late sample change ignored
        conv_int("R10", 12'h800, 12'hFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
                 CONV_CYCLES, 16, 16'hBF10, 1'b1);
        // R11 R12: second command while busy
        conv_int("R11", 12'h456, 12'h456, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1,
                 CONV_CYCLES, 16, 16'h8000, 1'b0);
        // R6 R8: host read started by strobe rise
        host_read("R6", 1'b0, 16'h4560, 4'b1011);
        // R7 R8: host read started by select fall
        host_read("R7", 1'b1, 16'h4560, 4'b0110);
        // R13 then R9 (two's complement of 0x9AB is 0x1AB)
        read_during_conv();
        host_read("R9", 1'b1, 16'h1AB0, 4'b0000);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule